// File: doc/BRIEF.md
# General-purpose I/O port with configuration freeze

This block is a 16-pin general-purpose I/O port controlled from a simple 32-bit register bus. Each pin has a 4-bit configuration field. The two low bits pick input or output. The two high bits pick the input flavour (analog, floating, pulled) or the output flavour (general-purpose or alternate function, push-pull or open-drain). Pins 0 to 7 sit in one configuration word and pins 8 to 15 in a second. Field `p` occupies bits `4*(p mod 8)+3 : 4*(p mod 8)`, with the direction bits in `[1:0]` and the flavour bits in `[3:2]`.

The output value of each pin comes from an output word. That word can be written whole, changed bit-atomically through a set/clear word, or cleared through a clear-only word. When a pin is configured as a pulled input, its output bit chooses the pull direction. The pins are sampled into an input word every clock. The block drives registered per-pin pad controls: output value, output enable, open-drain, alternate-function select, pull enable and pull direction.

A key sequence on the freeze word locks the configuration fields of selected pins until reset. The sequence is three writes with the same pin mask: key bit 16 set, then cleared, then set again. The output word stays writable while pins are locked.

Top module: `gpio_lock_port`

## Requirements
- R1: After reset both configuration words read 0x44444444, the output word reads 0, the freeze word reads 0, and every pad control output is 0.
- R2: Word address 0 holds pins 0-7 and address 1 holds pins 8-15. Field p is at bit offset 4*(p mod 8). A write to either word stores all 32 bits for unlocked pins and reads back unchanged.
- R3: A pin whose field bits [1:0] are nonzero has pad_oe=1. Field bit 2 drives pad_od and field bit 3 drives pad_af. All pad outputs settle on the second rising edge after the bus write.
- R4: With field bits [1:0]=00, the pin has pad_oe=0. Flavour bits [3:2]=10 set pad_pull_en, and pad_pull_up then equals the pin's output-word bit. Flavours 00, 01 and 11 leave the pull disabled.
- R5: A write to address 3 loads bits [15:0] into the output word and ignores bits [31:16]. pad_out follows the output word.
- R6: A write to address 4 sets the output bits where wdata[15:0] is 1 and clears those where wdata[31:16] is 1. Zero bits leave the output unchanged. When both bits for one pin are 1, the set wins.
- R7: A write to address 5 clears the output bits where wdata[15:0] is 1. Bits [31:16] of that write are ignored.
- R8: Address 2 returns the pins as sampled on the previous clock. Writes to address 2 have no effect.
- R9: Three writes to address 6 with wdata[16] equal to 1, then 0, then 1, all with the same wdata[15:0] mask, lock the port. After this, address 6 reads bit 16 as 1 and bits [15:0] as the mask.
- R10: While locked, the configuration fields of masked pins ignore writes. Unmasked fields and the output word remain writable.
- R11: A freeze-word write that breaks the 1-0-1 key order, or that changes the mask partway through, aborts the sequence. The port stays unlocked, and address 6 reads bit 16 as 0 with bits [15:0] equal to the last mask written.
- R12: Once locked, writes to address 6 are ignored. Only reset releases the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_addr | input | 3 | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data of the word at bus_addr |
| pin_in | input | 16 | Pin levels from the pads |
| pad_out | output | 16 | Per-pin output value |
| pad_oe | output | 16 | Per-pin output enable |
| pad_od | output | 16 | Per-pin open-drain select |
| pad_af | output | 16 | Per-pin alternate-function select |
| pad_pull_en | output | 16 | Per-pin pull resistor enable |
| pad_pull_up | output | 16 | Per-pin pull direction, 1 for up |

## Verification
The bench targets a set/clear access that names the same pin in both halves. A design with the wrong precedence would leave that pin at 0 instead of 1. The bench also feeds key sequences that reverse the key order or change the mask on the second or the third write. A design that checks only the final write, or never compares masks, would lock on these and then refuse configuration writes. After a genuine lock, the bench writes all-zero and all-one configuration words and new freeze values. A design that gates the wrong half of the field, or re-arms the sequence, would change the frozen pins or the freeze readback. Pull direction is checked by flipping the output bits of pulled pins, which catches a design that ties the pull direction to the configuration field.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;
  localparam int PIN_COUNT = 16;
  localparam int FIELD_W   = 4;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 3;

  localparam logic [ADDR_W-1:0] A_CFG_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_IN     = 3'd2;
  localparam logic [ADDR_W-1:0] A_OUT    = 3'd3;
  localparam logic [ADDR_W-1:0] A_SETCLR = 3'd4;
  localparam logic [ADDR_W-1:0] A_CLR    = 3'd5;
  localparam logic [ADDR_W-1:0] A_LOCK   = 3'd6;

  localparam logic [FIELD_W-1:0] FIELD_RESET = 4'h4;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_KEY_ON  = 2'd1,
    SEQ_KEY_OFF = 2'd2
  } lock_seq_e;
endpackage

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank #(
  parameter int NPINS   = 16,
  parameter int FIELD_W = 4,
  parameter int DATA_W  = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_lo,
  input  logic                            wr_hi,
  input  logic [DATA_W-1:0]               wdata,
  input  logic [NPINS-1:0]                frozen,
  output logic [NPINS-1:0][FIELD_W-1:0]   cfg
);
  import gpio_lock_pkg::*;
  localparam int HALF = NPINS / 2;

  for (genvar i = 0; i < NPINS; i++) begin : g_field
    localparam int OFS = FIELD_W * (i % HALF);
    logic wr_sel;
    assign wr_sel = (i < HALF) ? wr_lo : wr_hi;

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[i] <= FIELD_RESET;
      end else if (wr_sel && !frozen[i]) begin
        cfg[i] <= wdata[OFS +: FIELD_W];
      end
    end

    // R10: a frozen field never moves
    assert_frozen_field_R10: assert property (@(posedge clk) disable iff (rst)
      frozen[i] |=> $stable(cfg[i]));
  end
endmodule

// File: rtl/gpio_out_data.sv
module gpio_out_data #(
  parameter int NPINS  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_full,
  input  logic              wr_setclr,
  input  logic              wr_clr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NPINS-1:0]  odr
);
  logic [NPINS-1:0] set_bits, clr_bits;
  assign set_bits = wdata[NPINS-1:0];
  assign clr_bits = wdata[2*NPINS-1:NPINS];

  always_ff @(posedge clk) begin
    if (rst) begin
      odr <= '0;
    end else if (wr_full) begin
      odr <= set_bits;
    end else if (wr_setclr) begin
      odr <= (odr & ~clr_bits) | set_bits;
    end else if (wr_clr) begin
      odr <= odr & ~set_bits;
    end
  end

  assert_set_bits_high_R6: assert property (@(posedge clk) disable iff (rst)
    wr_setclr |=> ((odr & $past(set_bits)) == $past(set_bits)));

  assert_clr_bits_low_R6: assert property (@(posedge clk) disable iff (rst)
    wr_setclr |=> ((odr & $past(clr_bits & ~set_bits)) == '0));

  assert_clr_only_R7: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> ((odr & $past(set_bits)) == '0));
endmodule

// File: rtl/gpio_lock_seq.sv
module gpio_lock_seq #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_lock,
  input  logic             key_in,
  input  logic [NPINS-1:0] mask_in,
  output logic             locked,
  output logic [NPINS-1:0] lck_bits,
  output logic [NPINS-1:0] frozen
);
  import gpio_lock_pkg::*;
  lock_seq_e state;
  logic      same_mask;
  assign same_mask = (mask_in == lck_bits);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      locked   <= 1'b0;
      lck_bits <= '0;
    end else if (wr_lock && !locked) begin
      lck_bits <= mask_in;
      unique case (state)
        SEQ_IDLE:    state <= key_in ? SEQ_KEY_ON : SEQ_IDLE;
        SEQ_KEY_ON:  state <= (!key_in && same_mask) ? SEQ_KEY_OFF : SEQ_IDLE;
        SEQ_KEY_OFF: begin
          state <= SEQ_IDLE;
          if (key_in && same_mask) locked <= 1'b1;
        end
        default:     state <= SEQ_IDLE;
      endcase
    end
  end

  assign frozen = locked ? lck_bits : '0;

  // R12: lock holds and its mask stays put until reset
  assert_lock_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    locked |=> (locked && $stable(lck_bits)));

  // R9: locking only happens on a keyed write that ends the sequence
  assert_lock_from_key_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(wr_lock && key_in && state == SEQ_KEY_OFF));
endmodule

// File: rtl/gpio_pin_decode.sv
module gpio_pin_decode #(
  parameter int NPINS   = 16,
  parameter int FIELD_W = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NPINS-1:0][FIELD_W-1:0] cfg,
  input  logic [NPINS-1:0]              odr,
  output logic [NPINS-1:0]              pad_out,
  output logic [NPINS-1:0]              pad_oe,
  output logic [NPINS-1:0]              pad_od,
  output logic [NPINS-1:0]              pad_af,
  output logic [NPINS-1:0]              pad_pull_en,
  output logic [NPINS-1:0]              pad_pull_up
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic is_out, is_pull;
    assign is_out  = (cfg[i][1:0] != 2'b00);
    assign is_pull = !is_out && (cfg[i][3:2] == 2'b10);

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[i]     <= 1'b0;
        pad_oe[i]      <= 1'b0;
        pad_od[i]      <= 1'b0;
        pad_af[i]      <= 1'b0;
        pad_pull_en[i] <= 1'b0;
        pad_pull_up[i] <= 1'b0;
      end else begin
        pad_out[i]     <= odr[i];
        pad_oe[i]      <= is_out;
        pad_od[i]      <= is_out && cfg[i][2];
        pad_af[i]      <= is_out && cfg[i][3];
        pad_pull_en[i] <= is_pull;
        pad_pull_up[i] <= is_pull && odr[i];
      end
    end
  end

  assert_od_needs_oe_R3: assert property (@(posedge clk) disable iff (rst)
    ((pad_od | pad_af) & ~pad_oe) == '0);

  assert_no_pull_on_output_R4: assert property (@(posedge clk) disable iff (rst)
    (pad_pull_en & pad_oe) == '0);

  assert_pull_dir_gated_R4: assert property (@(posedge clk) disable iff (rst)
    (pad_pull_up & ~pad_pull_en) == '0);
endmodule

// File: rtl/gpio_lock_port.sv
module gpio_lock_port #(
  parameter int NPINS   = gpio_lock_pkg::PIN_COUNT,
  parameter int FIELD_W = gpio_lock_pkg::FIELD_W,
  parameter int DATA_W  = gpio_lock_pkg::DATA_W,
  parameter int ADDR_W  = gpio_lock_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_od,
  output logic [NPINS-1:0]  pad_af,
  output logic [NPINS-1:0]  pad_pull_en,
  output logic [NPINS-1:0]  pad_pull_up
);
  import gpio_lock_pkg::*;
  localparam int HALF = NPINS / 2;
  localparam int PAD0 = DATA_W - NPINS;
  localparam int PAD1 = DATA_W - NPINS - 1;

  logic [NPINS-1:0][FIELD_W-1:0] cfg;
  logic [NPINS-1:0] odr, in_reg, lck_bits, frozen;
  logic             locked;

  logic wr_lo, wr_hi, wr_full, wr_setclr, wr_clr, wr_lock;
  assign wr_lo     = bus_wr && (bus_addr == A_CFG_LO);
  assign wr_hi     = bus_wr && (bus_addr == A_CFG_HI);
  assign wr_full   = bus_wr && (bus_addr == A_OUT);
  assign wr_setclr = bus_wr && (bus_addr == A_SETCLR);
  assign wr_clr    = bus_wr && (bus_addr == A_CLR);
  assign wr_lock   = bus_wr && (bus_addr == A_LOCK);

  gpio_cfg_bank #(.NPINS(NPINS), .FIELD_W(FIELD_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(bus_wdata), .frozen(frozen), .cfg(cfg));

  gpio_out_data #(.NPINS(NPINS), .DATA_W(DATA_W)) u_odr (
    .clk(clk), .rst(rst), .wr_full(wr_full), .wr_setclr(wr_setclr),
    .wr_clr(wr_clr), .wdata(bus_wdata), .odr(odr));

  gpio_lock_seq #(.NPINS(NPINS)) u_lock (
    .clk(clk), .rst(rst), .wr_lock(wr_lock), .key_in(bus_wdata[NPINS]),
    .mask_in(bus_wdata[NPINS-1:0]), .locked(locked), .lck_bits(lck_bits),
    .frozen(frozen));

  gpio_pin_decode #(.NPINS(NPINS), .FIELD_W(FIELD_W)) u_dec (
    .clk(clk), .rst(rst), .cfg(cfg), .odr(odr),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .pad_af(pad_af),
    .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up));

  always_ff @(posedge clk) begin
    if (rst) begin
      in_reg    <= '0;
      bus_rdata <= '0;
    end else begin
      in_reg <= pin_in;
      unique case (bus_addr)
        A_CFG_LO: bus_rdata <= cfg[HALF-1:0];
        A_CFG_HI: bus_rdata <= cfg[NPINS-1:HALF];
        A_IN:     bus_rdata <= {{PAD0{1'b0}}, in_reg};
        A_OUT:    bus_rdata <= {{PAD0{1'b0}}, odr};
        A_LOCK:   bus_rdata <= {{PAD1{1'b0}}, locked, lck_bits};
        default:  bus_rdata <= '0;
      endcase
    end
  end

  // R8: the input word never depends on bus writes
  assert_in_sampled_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (in_reg == $past(pin_in)));
endmodule

// File: tb/gpio_lock_port_tb.sv
module gpio_lock_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VEC_N = 12;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in = 16'h3C3C;
  logic [15:0] pad_out, pad_oe, pad_od, pad_af, pad_pull_en, pad_pull_up;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_lock_port u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .pad_af(pad_af),
    .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up));

  typedef struct packed {
    logic [2:0]  wa;
    logic [31:0] wd;
    logic [2:0]  ra;
    logic [31:0] ex;
    logic [3:0]  rq;
  } vec_t;

  localparam vec_t VEC [VEC_N] = '{
    {3'd3, 32'h0000_A5A5, 3'd3, 32'h0000_A5A5, 4'd5},
    {3'd3, 32'hFFFF_0000, 3'd3, 32'h0000_0000, 4'd5},
    {3'd4, 32'h0000_0011, 3'd3, 32'h0000_0011, 4'd6},
    {3'd4, 32'h0001_0100, 3'd3, 32'h0000_0110, 4'd6},
    {3'd4, 32'h0010_0010, 3'd3, 32'h0000_0110, 4'd6},
    {3'd4, 32'h0000_0000, 3'd3, 32'h0000_0110, 4'd6},
    {3'd5, 32'hFFFF_0100, 3'd3, 32'h0000_0010, 4'd7},
    {3'd0, 32'h1234_ABCD, 3'd0, 32'h1234_ABCD, 4'd2},
    {3'd1, 32'h8765_4321, 3'd1, 32'h8765_4321, 4'd2},
    {3'd2, 32'hFFFF_FFFF, 3'd2, 32'h0000_3C3C, 4'd8},
    {3'd0, 32'h4444_4444, 3'd0, 32'h4444_4444, 4'd2},
    {3'd1, 32'h4444_4444, 3'd1, 32'h4444_4444, 4'd2}
  };

  function automatic string req_tag(logic [3:0] n);
    case (n)
      4'd2: return "R2";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R?";
    endcase
  endfunction

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [31:0] d);
    bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic expect_read(string tag, logic [2:0] a, logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check32(tag, d, exp);
  endtask

  task automatic check_pads(string tag, logic [15:0] e_out, logic [15:0] e_oe,
                            logic [15:0] e_od, logic [15:0] e_af,
                            logic [15:0] e_pe, logic [15:0] e_pu);
    @(negedge clk);
    check32({tag, " pad_out"}, {16'h0, pad_out}, {16'h0, e_out});
    check32({tag, " pad_oe"}, {16'h0, pad_oe}, {16'h0, e_oe});
    check32({tag, " pad_od"}, {16'h0, pad_od}, {16'h0, e_od});
    check32({tag, " pad_af"}, {16'h0, pad_af}, {16'h0, e_af});
    check32({tag, " pad_pull_en"}, {16'h0, pad_pull_en}, {16'h0, e_pe});
    check32({tag, " pad_pull_up"}, {16'h0, pad_pull_up}, {16'h0, e_pu});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check_pads("R1", 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0);
    expect_read("R1 cfg_lo", 3'd0, 32'h4444_4444);
    expect_read("R1 cfg_hi", 3'd1, 32'h4444_4444);
    expect_read("R1 out", 3'd3, 32'h0);
    expect_read("R1 lock", 3'd6, 32'h0);

    // Vector table: write, then read back
    for (int v = 0; v < VEC_N; v++) begin
      bus_write(VEC[v].wa, VEC[v].wd);
      expect_read(req_tag(VEC[v].rq), VEC[v].ra, VEC[v].ex);
    end

    // R3 / R4: pad decode, including the high word (pin 15)
    bus_write(3'd0, 32'h4088_E951);
    bus_write(3'd1, 32'h1444_4444);
    bus_write(3'd3, 32'h0000_0011);
    check_pads("R3", 16'h0011, 16'h800F, 16'h000A, 16'h000C, 16'h0030, 16'h0010);
    // R4: pull direction follows the output bit
    bus_write(3'd4, 32'h0010_0020);
    check_pads("R4", 16'h0021, 16'h800F, 16'h000A, 16'h000C, 16'h0030, 16'h0020);

    // R11: wrong key order
    bus_write(3'd6, 32'h0000_0003);
    bus_write(3'd6, 32'h0001_0003);
    bus_write(3'd6, 32'h0001_0003);
    expect_read("R11 order", 3'd6, 32'h0000_0003);
    // R11: mask changed on the second write, then on the third
    bus_write(3'd6, 32'h0001_0003);
    bus_write(3'd6, 32'h0000_0007);
    bus_write(3'd6, 32'h0001_0007);
    bus_write(3'd6, 32'h0000_0007);
    bus_write(3'd6, 32'h0001_0003);
    expect_read("R11 mask", 3'd6, 32'h0000_0003);
    bus_write(3'd0, 32'h4088_E955);
    expect_read("R11 cfg writable", 3'd0, 32'h4088_E955);

    // R9: genuine lock of pins 0 and 15
    bus_write(3'd6, 32'h0001_8001);
    bus_write(3'd6, 32'h0000_8001);
    bus_write(3'd6, 32'h0001_8001);
    expect_read("R9", 3'd6, 32'h0001_8001);

    // R10: frozen fields keep their values, others and output still move
    bus_write(3'd0, 32'h0000_0000);
    expect_read("R10 lo", 3'd0, 32'h0000_0005);
    bus_write(3'd1, 32'h0000_0000);
    expect_read("R10 hi", 3'd1, 32'h1000_0000);
    bus_write(3'd3, 32'h0000_1234);
    expect_read("R10 out", 3'd3, 32'h0000_1234);

    // R12: freeze word writes ignored once locked
    bus_write(3'd6, 32'h0000_0000);
    expect_read("R12 lock", 3'd6, 32'h0001_8001);
    bus_write(3'd6, 32'h0001_FFFF);
    bus_write(3'd0, 32'hFFFF_FFF0);
    expect_read("R12 cfg", 3'd0, 32'hFFFF_FFF5);

    // R12: reset releases the lock
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    expect_read("R12 after reset", 3'd6, 32'h0);
    expect_read("R1 cfg after reset", 3'd0, 32'h4444_4444);
    bus_write(3'd0, 32'h0000_0000);
    expect_read("R12 unlocked cfg", 3'd0, 32'h0000_0000);

    finish_run();
  end
endmodule